// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit keeps the interrupt state of one DMA channel. Four event strobes come in from the channel engine: bus-error abort, block transfer done, wrap complete (count reached zero) and wrap half-way (count reached half of the programmed count). Each strobe sets a sticky flag in a status word. Software clears a flag by writing a one to its position in that status word.

A small write port also loads a three-bit enable word and a four-bit wrap select. The channel interrupt line is raised while any flag is set together with its enable. For the two wrap flags, the matching select bit must also be set. Wrap flags only take an event while the channel's source or destination addressing is in wrap mode, as signalled on `wrap_mode`. Bit 31 of the status word shows the level of the interrupt line, and software cannot write it.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, `status_o`, `ien_o`, `wsel_o` and `irq_o` are all zero.
- R2: A high `ev_abort` on a clock edge sets status bit 0, and the bit stays set until it is cleared.
- R3: A high `ev_done` on a clock edge sets status bit 1, and the bit stays set until it is cleared.
- R4: `ev_wrap_full` sets status bit 8 (wrap field value 0001) and `ev_wrap_half` sets status bit 10 (wrap field value 0100). Each does so only when `wrap_mode` is high in the same cycle. Status bits 9, 11 and 30 to 12 always read zero.
- R5: A write with `wr_addr` = 2 clears each flag (status bits 0, 1, 8, 10) whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: If an event strobe and a clearing write to the same flag occur in one cycle, the flag is set after that edge.
- R7: `irq_o` = (bit0 AND ien[0]) OR (bit1 AND ien[1]) OR (ien[2] AND ((bit8 AND wsel[0]) OR (bit10 AND wsel[2]))). Select bits 1 and 3 have no effect.
- R8: Status bit 31 always equals `irq_o`.
- R9: A write with `wr_addr` = 0 loads `ien_o` from `wr_data[2:0]`. A write with `wr_addr` = 1 loads `wsel_o` from `wr_data[3:0]`. A write with `wr_addr` = 3 changes nothing.
- R10: A flag becomes visible in the cycle after the edge that samples its strobe, and `irq_o` follows in that same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_abort | input | 1 | Bus-error abort strobe |
| ev_done | input | 1 | Block transfer done strobe |
| ev_wrap_full | input | 1 | Wrap count reached zero strobe |
| ev_wrap_half | input | 1 | Wrap count reached half strobe |
| wrap_mode | input | 1 | Source or destination addressing is in wrap mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write target: 0 enables, 1 wrap select, 2 status clear |
| wr_data | input | DATA_W (32) | Write data |
| ien_o | output | 3 | Enable word |
| wsel_o | output | 4 | Wrap select word |
| status_o | output | DATA_W (32) | Status word with flags and the pin level in bit 31 |
| irq_o | output | 1 | Channel interrupt line |

## Verification
A vector table drives each event strobe alone and in groups, under enable words that each switch on one source or none. This shows that every flag lands in its own bit and that the interrupt gating uses only the matching enable. The wrap vectors pair each wrap event with each select bit, including the reserved select bits 1 and 3, and repeat with `wrap_mode` low. These cases separate a missing select mask, swapped select bits and a missing wrap-mode qualifier. Directed tests then cover partial and all-zero clearing writes, a clear that collides with a set, writes to the unused address, and the one-cycle latency from a strobe to the flag and the line.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int IEN_W     = 3;
    localparam int SEL_W     = 4;

    // flag indices inside the flag vector
    localparam int FLG_ABORT = 0;
    localparam int FLG_DONE  = 1;
    localparam int FLG_WFULL = 2;
    localparam int FLG_WHALF = 3;

    // bit positions inside the status word
    localparam int POS_ABORT = 0;
    localparam int POS_DONE  = 1;
    localparam int POS_WFULL = 8;
    localparam int POS_WHALF = 10;
    localparam int POS_PIN   = 31;

    // enable and select bit positions
    localparam int IEN_ABORT = 0;
    localparam int IEN_DONE  = 1;
    localparam int IEN_WRAP  = 2;
    localparam int SEL_FULL  = 0;
    localparam int SEL_HALF  = 2;

    typedef enum logic [1:0] {
        TGT_ENABLE = 2'd0,
        TGT_SELECT = 2'd1,
        TGT_STATUS = 2'd2,
        TGT_NONE   = 2'd3
    } wr_target_e;

    typedef struct packed {
        logic [IEN_W-1:0] ien;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    function automatic int flag_pos(input int idx);
        case (idx)
            FLG_ABORT: return POS_ABORT;
            FLG_DONE:  return POS_DONE;
            FLG_WFULL: return POS_WFULL;
            default:   return POS_WHALF;
        endcase
    endfunction

endpackage

// File: rtl/dma_irq_cfg.sv
module dma_irq_cfg
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ien,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ien) begin
            cfg_d.ien = wr_data[IEN_W-1:0];
        end
        if (wr_sel) begin
            cfg_d.sel = wr_data[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_d, flags_q;

    // a set in the same cycle as a clear wins
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = set_i[i] | (flags_q[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  cfg_t                 cfg_i,
    output logic                 irq_o,
    output logic [DATA_W-1:0]    status_o
);

    logic wrap_hit;
    logic line;

    always_comb begin
        wrap_hit = (flags_i[FLG_WFULL] & cfg_i.sel[SEL_FULL])
                 | (flags_i[FLG_WHALF] & cfg_i.sel[SEL_HALF]);
        line     = (flags_i[FLG_ABORT] & cfg_i.ien[IEN_ABORT])
                 | (flags_i[FLG_DONE]  & cfg_i.ien[IEN_DONE])
                 | (wrap_hit           & cfg_i.ien[IEN_WRAP]);
    end

    always_comb begin
        status_o = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            status_o[flag_pos(i)] = flags_i[i];
        end
        status_o[POS_PIN] = line;
    end

    assign irq_o = line;

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_abort,
    input  logic              ev_done,
    input  logic              ev_wrap_full,
    input  logic              ev_wrap_half,
    input  logic              wrap_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IEN_W-1:0]  ien_o,
    output logic [SEL_W-1:0]  wsel_o,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_o
);

    logic                 wr_ien, wr_sel, wr_stat;
    logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
    cfg_t                 cfg;

    always_comb begin
        wr_ien  = wr_en && (wr_addr == ADDR_W'(TGT_ENABLE));
        wr_sel  = wr_en && (wr_addr == ADDR_W'(TGT_SELECT));
        wr_stat = wr_en && (wr_addr == ADDR_W'(TGT_STATUS));
    end

    always_comb begin
        set_v            = '0;
        set_v[FLG_ABORT] = ev_abort;
        set_v[FLG_DONE]  = ev_done;
        set_v[FLG_WFULL] = ev_wrap_full & wrap_mode;
        set_v[FLG_WHALF] = ev_wrap_half & wrap_mode;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            clr_v[i] = wr_stat & wr_data[flag_pos(i)];
        end
    end

    dma_irq_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ien  (wr_ien),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    dma_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flags_o (flags)
    );

    dma_irq_combine #(.DATA_W(DATA_W)) u_comb (
        .flags_i  (flags),
        .cfg_i    (cfg),
        .irq_o    (irq_o),
        .status_o (status_o)
    );

    assign ien_o  = cfg.ien;
    assign wsel_o = cfg.sel;

endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_abort,
    input logic              ev_done,
    input logic              ev_wrap_full,
    input logic              wrap_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] status_o,
    input logic              irq_o
);

    AST_ABORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> status_o[0]); // R2

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> status_o[1]); // R3

    AST_WRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[8] && !(ev_wrap_full && wrap_mode)) |=> !status_o[8]); // R4

    AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(2) && wr_data[1] && !ev_done) |=> !status_o[1]); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_abort && wr_en && wr_addr == ADDR_W'(2) && wr_data[0]) |=> status_o[0]); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[0] || status_o[1] || status_o[8] || status_o[10])); // R7

endmodule

bind dma_irq_status dma_irq_status_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_abort     (ev_abort),
    .ev_done      (ev_done),
    .ev_wrap_full (ev_wrap_full),
    .wrap_mode    (wrap_mode),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_abort = 1'b0, ev_done = 1'b0, ev_wrap_full = 1'b0, ev_wrap_half = 1'b0;
    logic        wrap_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  ien_o;
    logic [3:0]  wsel_o;
    logic [31:0] status_o;
    logic        irq_o;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dma_irq_status dut (
        .clk(clk), .rst_n(rst_n),
        .ev_abort(ev_abort), .ev_done(ev_done),
        .ev_wrap_full(ev_wrap_full), .ev_wrap_half(ev_wrap_half),
        .wrap_mode(wrap_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ien_o(ien_o), .wsel_o(wsel_o), .status_o(status_o), .irq_o(irq_o)
    );

    // ien, sel, wrap_mode, events {half,full,done,abort}, expected flag bits, expected line
    typedef struct packed {
        logic [2:0]  ien;
        logic [3:0]  sel;
        logic        wm;
        logic [3:0]  ev;
        logic [11:0] stat;
        logic        irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'b001, 4'b0000, 1'b0, 4'b0001, 12'h001, 1'b1}, // R2 R7
        '{3'b000, 4'b0000, 1'b0, 4'b0001, 12'h001, 1'b0}, // R2 R7
        '{3'b010, 4'b0000, 1'b0, 4'b0010, 12'h002, 1'b1}, // R3 R7
        '{3'b001, 4'b0000, 1'b0, 4'b0010, 12'h002, 1'b0}, // R3 R7
        '{3'b100, 4'b0001, 1'b1, 4'b0100, 12'h100, 1'b1}, // R4 R7
        '{3'b100, 4'b0100, 1'b1, 4'b0100, 12'h100, 1'b0}, // R4 R7
        '{3'b100, 4'b0100, 1'b1, 4'b1000, 12'h400, 1'b1}, // R4 R7
        '{3'b100, 4'b0101, 1'b0, 4'b1100, 12'h000, 1'b0}, // R4
        '{3'b011, 4'b0101, 1'b1, 4'b1111, 12'h503, 1'b1}, // R2 R3 R4
        '{3'b100, 4'b1010, 1'b1, 4'b1100, 12'h500, 1'b0}, // R7 reserved select
        '{3'b000, 4'b0101, 1'b1, 4'b1100, 12'h500, 1'b0}, // R7
        '{3'b100, 4'b0101, 1'b1, 4'b1000, 12'h400, 1'b1}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic wm, input logic [3:0] ev);
        @(negedge clk);
        wrap_mode = wm;
        {ev_wrap_half, ev_wrap_full, ev_done, ev_abort} = ev;
        @(posedge clk); #1;
        {ev_wrap_half, ev_wrap_full, ev_done, ev_abort} = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 status", status_o, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 ien", {29'b0, ien_o}, 32'h0);
        check("R1 wsel", {28'b0, wsel_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(2'd2, 32'hFFFF_FFFF);
            wr(2'd0, {29'b0, VECS[i].ien});
            wr(2'd1, {28'b0, VECS[i].sel});
            pulse(VECS[i].wm, VECS[i].ev);
            check($sformatf("R7 R8 vector %0d status", i), status_o,
                  {VECS[i].irq, 19'b0, VECS[i].stat});
            check($sformatf("R7 vector %0d irq", i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
        end

        // R9 readback and ignored address
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        check("R9 ien load", {29'b0, ien_o}, 32'h7);
        wr(2'd1, 32'hFFFF_FFF5);
        check("R9 wsel load", {28'b0, wsel_o}, 32'h5);
        wr(2'd3, 32'h0);
        check("R9 addr3 ien", {29'b0, ien_o}, 32'h7);
        check("R9 addr3 wsel", {28'b0, wsel_o}, 32'h5);
        check("R9 addr3 status", status_o, 32'h0);

        // all flags set
        pulse(1'b1, 4'b1111);
        check("R4 R8 all flags", status_o, 32'h8000_0503);

        // R5 zero write keeps all, partial clears
        wr(2'd2, 32'h0);
        check("R5 zero write", status_o, 32'h8000_0503);
        wr(2'd2, 32'h0000_0001);
        check("R5 clear abort", status_o, 32'h8000_0502);
        wr(2'd2, 32'h0000_0100);
        check("R5 clear wrap full", status_o, 32'h8000_0402);
        wr(2'd2, 32'h0000_0402);
        check("R5 clear rest", status_o, 32'h0);
        check("R5 R7 irq low", {31'b0, irq_o}, 32'h0);

        // R6 set and clear collide
        @(negedge clk);
        ev_abort = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h0000_0001;
        @(posedge clk); #1;
        ev_abort = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R6 set wins", status_o, 32'h8000_0001);
        wr(2'd2, 32'hFFFF_FFFF);

        // R10 latency
        @(negedge clk);
        ev_done = 1'b1;
        #2;
        check("R10 before edge", {status_o[31], status_o[1]}, 32'h0);
        @(posedge clk); #1;
        ev_done = 1'b0;
        check("R10 after edge", status_o, 32'h8000_0002);
        check("R10 irq same cycle", {31'b0, irq_o}, 32'h1);

        summary();
        $finish;
    end

endmodule